// File: doc/BRIEF.md
# SDRAM Command Front-End with Clock-Enable Gating

This block is the input stage on the device side of a four-bank SDRAM. It samples the clock enable, the active-low chip select and strobes, the bank select bits and the multiplexed address on every rising clock edge. It turns them into one decoded command per accepted edge and keeps an idle or active flag for each bank. It also holds the last bank and row from an activate, the last bank and column from a read or write, and the last mode word.

Clock enable gates the whole stage. An edge is accepted when clock enable is high at that edge or was high at the edge before. This gives three properties:
- The command on the edge where clock enable first drops still executes.
- Later edges are ignored while clock enable stays low, and every output holds its value.
- Leaving the low state takes effect on the same edge where clock enable is seen high again.

When clock enable drops with every bank idle, the block reports power-down. When it drops with any bank open, the block is only in clock suspend, and the power-down flag stays low.

Top module: `sdram_cmd_frontend`

## Requirements
- R1: Command decode, with codes on `cmd_o`. `cs_ni` high gives DESELECT (1). With `cs_ni` low, {ras,cas,we} gives: 111 NOP (0), 011 ACTIVATE (2), 101 READ (3), 100 WRITE (4), 010 PRECHARGE (5), 001 REFRESH (6), 000 MODE SET (7). The combination 110 is treated as NOP (0).
- R2: `cmd_o` is registered. After each accepted edge it shows the command decoded at that edge.
- R3: An edge is accepted only if `cke_i` is high at that edge or was high at the previous edge. `clk_en_o` shows this combinationally for the coming edge.
- R4: An accepted ACTIVATE sets bit `bank_i` of `bank_active_o`.
- R5: An accepted PRECHARGE clears bit `bank_i` of `bank_active_o`. If `addr_i[10]` is high, it clears all four bits.
- R6: An accepted ACTIVATE loads `addr_i` into `row_o` and `bank_i` into `cmd_bank_o`.
- R7: An accepted READ or WRITE loads `addr_i[7:0]` into `col_o` and `bank_i` into `cmd_bank_o`.
- R8: An accepted MODE SET loads {`bank_i`,`addr_i`} into `mode_o` and `bank_i` into `cmd_bank_o`. An accepted PRECHARGE also loads `bank_i` into `cmd_bank_o`.
- R9: `pwr_down_o` rises after an accepted edge where `cke_i` is low and all banks are idle after that edge's command. It clears after any edge where `cke_i` is high. It stays low during clock suspend, when a bank is still active.
- R10: On an edge that is not accepted, all registered outputs hold their values, whatever the command and address inputs are.
- R11: During reset, all registered outputs are zero, `cmd_o` is NOP, and the previous clock enable is taken as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| bank_i | input | 2 | Bank select |
| addr_i | input | 12 | Multiplexed address |
| clk_en_o | output | 1 | Coming edge will be accepted |
| pwr_down_o | output | 1 | Power-down status |
| cmd_o | output | 3 | Last accepted command code |
| bank_active_o | output | 4 | Per-bank active flags |
| cmd_bank_o | output | 2 | Last latched bank |
| row_o | output | 12 | Last activated row |
| col_o | output | 8 | Last read/write column |
| mode_o | output | 14 | Last mode word |

## Verification
A wrong bank flag shows up one cycle after the command in `bank_active_o`. Later it also shows up in `pwr_down_o`: with a flag stuck set, power-down is never entered, and with a flag stuck clear, it is entered too early. A wrong clock-enable history shows at the ports in two ways:
- `clk_en_o` is wrong at once.
- Outputs move on an edge that should be ignored, or stay frozen on the exit edge. This appears one cycle later.

The bench runs a shadow model and compares every output at every edge, so each fault of this kind is reported in the cycle it first becomes visible.

// File: rtl/sdram_fe_pkg.sv
package sdram_fe_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_DESEL  = 3'd1,
    CMD_ACT    = 3'd2,
    CMD_RD     = 3'd3,
    CMD_WR     = 3'd4,
    CMD_PRE    = 3'd5,
    CMD_REF    = 3'd6,
    CMD_MRS    = 3'd7
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_fe_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) cmd_o = CMD_DESEL;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic all_idle_nxt_i,
  output logic acc_o,
  output logic pwr_down_o
);
  logic cke_q, pd_q;

  // exit on the same edge CKE is seen high; first low edge still executes
  assign acc_o      = cke_i | cke_q;
  assign pwr_down_o = pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      cke_q <= cke_i;
      if (cke_i)      pd_q <= 1'b0;
      else if (acc_o) pd_q <= all_idle_nxt_i;
    end
  end

  p_pd_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i |=> !pwr_down_o);
  p_pd_from_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_down_o) |-> $past(!cke_i));
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_fe_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_i,
  input  cmd_e                 cmd_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 all_i,
  output logic [NUM_BANKS-1:0] active_o,
  output logic                 all_idle_nxt_o
);
  logic [NUM_BANKS-1:0] active_q, active_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BANK_W'(b));
    always_comb begin
      active_d[b] = active_q[b];
      if (acc_i) begin
        if (cmd_i == CMD_ACT && sel)                 active_d[b] = 1'b1;
        else if (cmd_i == CMD_PRE && (sel || all_i)) active_d[b] = 1'b0;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) active_q[b] <= 1'b0;
      else         active_q[b] <= active_d[b];
    end
  end

  assign active_o       = active_q;
  assign all_idle_nxt_o = (active_d == '0);

  p_act_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && cmd_i == CMD_ACT) |=> active_q[$past(bank_i)]);
  p_pre_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && cmd_i == CMD_PRE && all_i) |=> (active_q == '0));
  p_frozen_banks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(active_q));
endmodule

// File: rtl/sdram_cmd_frontend.sv
module sdram_cmd_frontend
  import sdram_fe_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int MODE_W   = BANK_W + ROW_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [ROW_W-1:0]     addr_i,
  output logic                 clk_en_o,
  output logic                 pwr_down_o,
  output logic [2:0]           cmd_o,
  output logic [NUM_BANKS-1:0] bank_active_o,
  output logic [BANK_W-1:0]    cmd_bank_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o,
  output logic [MODE_W-1:0]    mode_o
);
  cmd_e cmd_dec, cmd_q;
  logic acc, all_idle_nxt;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [MODE_W-1:0] mode_q;

  sdram_cmd_decode u_dec (
    .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd_dec)
  );

  sdram_cke_ctrl u_cke (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i),
    .all_idle_nxt_i(all_idle_nxt), .acc_o(acc), .pwr_down_o(pwr_down_o)
  );

  sdram_bank_tracker #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_banks (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .cmd_i(cmd_dec), .bank_i(bank_i),
    .all_i(addr_i[AP_BIT]), .active_o(bank_active_o), .all_idle_nxt_o(all_idle_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      mode_q <= '0;
    end else if (acc) begin
      cmd_q <= cmd_dec;
      unique case (cmd_dec)
        CMD_ACT: begin
          row_q  <= addr_i;
          bank_q <= bank_i;
        end
        CMD_RD, CMD_WR: begin
          col_q  <= addr_i[COL_W-1:0];
          bank_q <= bank_i;
        end
        CMD_PRE: bank_q <= bank_i;
        CMD_MRS: begin
          mode_q <= {bank_i, addr_i};
          bank_q <= bank_i;
        end
        default: ;
      endcase
    end
  end

  assign clk_en_o   = acc;
  assign cmd_o      = cmd_q;
  assign cmd_bank_o = bank_q;
  assign row_o      = row_q;
  assign col_o      = col_q;
  assign mode_o     = mode_q;

  p_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> ($stable(cmd_q) && $stable(row_q) && $stable(col_q) && $stable(mode_q)
              && $stable(bank_q)));
  p_pd_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_o |-> (bank_active_o == '0));
  p_row_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_dec == CMD_ACT) |=> (row_q == $past(addr_i)));
endmodule

// File: tb/sdram_cmd_frontend_bench.sv
module sdram_cmd_frontend_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] bank;
  logic [11:0] addr;
  logic clk_en, pd;
  logic [2:0] cmd;
  logic [3:0] act;
  logic [1:0] cbank;
  logic [11:0] row;
  logic [7:0] col;
  logic [13:0] mode;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // shadow model
  logic m_ckq, m_pd;
  logic [2:0] m_cmd;
  logic [3:0] m_act;
  logic [1:0] m_bank;
  logic [11:0] m_row;
  logic [7:0] m_col;
  logic [13:0] m_mode;

  always #4 clk = ~clk;

  sdram_cmd_frontend u_sdram_cmd_frontend (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .bank_i(bank), .addr_i(addr),
    .clk_en_o(clk_en), .pwr_down_o(pd), .cmd_o(cmd), .bank_active_o(act),
    .cmd_bank_o(cbank), .row_o(row), .col_o(col), .mode_o(mode)
  );

  function automatic logic [2:0] f_dec(logic c, logic r, logic a, logic w);
    if (c) return 3'd1;
    case ({r, a, w})
      3'b011: return 3'd2;
      3'b101: return 3'd3;
      3'b100: return 3'd4;
      3'b010: return 3'd5;
      3'b001: return 3'd6;
      3'b000: return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  task automatic check_regs();
    check("R1 cmd", 32'(cmd), 32'(m_cmd));
    check("R4 bank_active", 32'(act), 32'(m_act));
    check("R6 cmd_bank", 32'(cbank), 32'(m_bank));
    check("R6 row", 32'(row), 32'(m_row));
    check("R7 col", 32'(col), 32'(m_col));
    check("R8 mode", 32'(mode), 32'(m_mode));
    check("R9 pwr_down", 32'(pd), 32'(m_pd));
  endtask

  task automatic model_edge();
    logic a;
    logic [2:0] d;
    a = cke | m_ckq;
    d = f_dec(cs_n, ras_n, cas_n, we_n);
    if (a) begin
      m_cmd = d;
      case (d)
        3'd2: begin m_act[bank] = 1'b1; m_row = addr; m_bank = bank; end
        3'd3, 3'd4: begin m_col = addr[7:0]; m_bank = bank; end
        3'd5: begin
          m_bank = bank;
          if (addr[10]) m_act = '0; else m_act[bank] = 1'b0;
        end
        3'd7: begin m_mode = {bank, addr}; m_bank = bank; end
        default: ;
      endcase
    end
    if (cke) m_pd = 1'b0;
    else if (a) m_pd = (m_act == '0);
    m_ckq = cke;
  endtask

  // drive one edge: check state, apply inputs, check R3 enable, advance model
  task automatic step(logic k, logic c, logic r, logic a, logic w, logic [1:0] b,
                      logic [11:0] ad);
    @(negedge clk);
    check_regs();
    cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; bank = b; addr = ad;
    #1;
    check("R3 clk_en", 32'(clk_en), 32'(k | m_ckq));
    model_edge();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [2:0] hold;
    seed = 32'd1234;
    void'($urandom(seed));
    cke = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    bank = '0; addr = '0;
    m_ckq = 0; m_pd = 0; m_cmd = 0; m_act = 0; m_bank = 0; m_row = 0; m_col = 0; m_mode = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check_regs();
    check("R11 clk_en in reset", 32'(clk_en), 32'(0));
    rst_ni = 1'b1;

    // directed: decode all codes (R1), latches (R6..R8)
    step(1, 0, 1, 1, 1, 2'd0, 12'h000);      // NOP
    step(1, 0, 0, 0, 0, 2'd3, 12'h5a5);      // MODE SET R8
    step(1, 0, 0, 1, 1, 2'd2, 12'habc);      // ACTIVATE bank2 R4 R6
    step(1, 0, 1, 0, 1, 2'd2, 12'h0fe);      // READ R7
    step(1, 0, 1, 0, 0, 2'd1, 12'h011);      // WRITE R7
    step(1, 0, 0, 0, 1, 2'd0, 12'h000);      // REFRESH
    step(1, 0, 1, 1, 0, 2'd0, 12'h000);      // 110 -> NOP R1
    step(1, 1, 0, 0, 0, 2'd1, 12'hfff);      // DESELECT R1
    step(1, 0, 0, 1, 1, 2'd0, 12'h123);      // ACTIVATE bank0
    // clock suspend with banks active: R9 stays low, R10 frozen
    step(0, 0, 1, 0, 1, 2'd1, 12'h044);      // READ still executes on drop
    step(0, 0, 0, 1, 1, 2'd3, 12'h777);      // ignored
    step(0, 0, 0, 0, 0, 2'd3, 12'h999);      // ignored
    @(negedge clk);
    check("R10 cmd frozen", 32'(cmd), 32'(3));
    check("R10 row frozen", 32'(row), 32'(12'h123));
    check("R9 suspend not pd", 32'(pd), 32'(0));
    // R5: precharge single, then all, exit on same edge as cke high
    step(1, 0, 0, 1, 0, 2'd2, 12'h000);      // PRE bank2 (exit edge, R3)
    step(1, 0, 0, 1, 0, 2'd1, 12'h400);      // PRE all R5
    // power-down entry with all idle
    step(0, 0, 1, 1, 1, 2'd0, 12'h000);
    step(0, 0, 0, 1, 1, 2'd1, 12'h222);      // ignored ACT in pd
    @(negedge clk);
    check("R9 pd entered", 32'(pd), 32'(1));
    check("R10 ignored act", 32'(act), 32'(0));
    step(1, 0, 0, 1, 1, 2'd3, 12'h333);      // exit and ACT same edge
    step(1, 0, 1, 1, 1, 2'd0, 12'h000);
    check("R2 cmd after exit", 32'(cmd), 32'(2));
    check("R9 pd cleared", 32'(pd), 32'(0));

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic k;
      k = ($urandom % 10) < 7;
      hold = 3'($urandom);
      step(k, ($urandom % 6) == 0, hold[2], hold[1], hold[0],
           2'($urandom), 12'($urandom));
    end
    @(negedge clk);
    check_regs();

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule